// File: doc/BRIEF.md
# Program Flow Sequencer with Return Stack

This block owns the instruction address of a small processor. On every instruction step it picks the next address. It can move to the following instruction, go to an absolute target, go to a target only when a 32-bit register value is zero, strictly positive or negative, enter a subroutine, or come back from one. Subroutine entry and exit use a bounded return-address stack held inside the block.

The decoder runs at a fraction of the system clock, so the sequencer changes state only on a clock edge where `step_en` is high. The decoder gives the operation code, the absolute target address and the register value to test. The block gives back the current address, the stack occupancy, and two sticky error flags. One flag records an attempted push onto a full stack. The other records an attempted pop from an empty stack.

Top module: `flow_sequencer`

## Requirements
- R1: While `rst_n` is low and after it is released, `pc` is 0, `stk_depth` is 0, and both `ovf_err` and `unf_err` are 0. Reset is the only thing that clears the two flags.
- R2: On an edge where `step_en` is low, `pc`, `stk_depth` and both flags keep their values, whatever the other inputs are.
- R3: For any `op_code` outside 5'b10000 to 5'b10101, a step sets `pc` to `pc + 1` modulo 2^ADDR_W. The address 2^22-1 wraps to 0.
- R4: `op_code` 5'b10000 loads `target` into `pc`.
- R5: `op_code` 5'b10001 loads `target` when `test_val` is all zeros. Otherwise it advances `pc` by one.
- R6: `op_code` 5'b10010 loads `target` only when `test_val` is strictly greater than zero in two's complement. A zero value, or a value with bit 31 set, advances `pc` by one.
- R7: `op_code` 5'b10011 loads `target` when bit 31 of `test_val` is set. Otherwise it advances `pc` by one.
- R8: `op_code` 5'b10100 with fewer than 8 entries on the stack pushes `pc + 1`, loads `target` into `pc`, and raises `stk_depth` by one.
- R9: `op_code` 5'b10101 with at least one entry on the stack loads the most recently pushed address into `pc` and lowers `stk_depth` by one. Returns are served in last-in first-out order.
- R10: A call made while the stack holds 8 entries pushes nothing and does not jump. `pc` advances by one, `stk_depth` stays at 8, and `ovf_err` is set and stays set.
- R11: A return made while the stack is empty pops nothing. `pc` advances by one, `stk_depth` stays at 0, and `unf_err` is set and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | One-cycle pulse that marks an instruction step |
| op_code | input | 5 | Operation code for this step |
| target | input | 22 | Absolute target address for a jump or call |
| test_val | input | 32 | Register value tested by the conditional jumps |
| pc | output | 22 | Current instruction address |
| stk_depth | output | 4 | Number of return addresses on the stack |
| ovf_err | output | 1 | Sticky flag for a call made on a full stack |
| unf_err | output | 1 | Sticky flag for a return made on an empty stack |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a 32-bit test value and a stack of 8 entries. With these values the wrap from 2^22-1 to 0 is one jump and one step away. Bit 31 of the test value can be driven directly, so the sign boundary cases of the conditional jumps can be tried. A chain of nine calls followed by nine returns fills the stack, pushes past full, drains it in order and pops past empty.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;
   localparam int OPC_W = 5;

   typedef enum logic [OPC_W-1:0] {
      OP_JMP  = 5'b10000,
      OP_JZ   = 5'b10001,
      OP_JPOS = 5'b10010,
      OP_JNEG = 5'b10011,
      OP_CALL = 5'b10100,
      OP_RET  = 5'b10101
   } flow_op_e;

   typedef enum logic [1:0] {
      COND_ALWAYS,
      COND_ZERO,
      COND_POS,
      COND_NEG
   } cond_sel_e;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
   import flow_seq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  cond_sel_e          sel,
   input  logic [DATA_W-1:0]  val,
   output logic               hit
);
   localparam int SIGN_B = DATA_W - 1;

   logic is_zero, is_neg, is_pos;

   assign is_zero = ~|val;
   assign is_neg  = val[SIGN_B];
   assign is_pos  = !is_zero && !is_neg;

   always_comb begin
      unique case (sel)
         COND_ZERO: hit = is_zero;
         COND_POS:  hit = is_pos;
         COND_NEG:  hit = is_neg;
         default:   hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack #(
   parameter int ADDR_W = 22,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_data,
   output logic [ADDR_W-1:0] top,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   logic [ADDR_W-1:0] ent [DEPTH];
   logic do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (do_push && count == CNT_W'(i))
            ent[i] <= push_data;
      end
   end

   always_comb begin
      top = '0;
      for (int k = 0; k < DEPTH; k++)
         if (count == CNT_W'(k + 1)) top = ent[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (do_push)
         count <= count + 1'b1;
      else if (do_pop)
         count <= count - 1'b1;
   end
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
   import flow_seq_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 32,
   parameter int STACK_DEPTH = 8,
   localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [OPC_W-1:0]  op_code,
   input  logic [ADDR_W-1:0] target,
   input  logic [DATA_W-1:0] test_val,
   output logic [ADDR_W-1:0] pc,
   output logic [CNT_W-1:0]  stk_depth,
   output logic              ovf_err,
   output logic              unf_err
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("flow_sequencer: ADDR_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("flow_sequencer: DATA_W must be at least 2");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("flow_sequencer: STACK_DEPTH must be at least 1");
   end

   logic [ADDR_W-1:0] pc_inc, pc_nxt, stk_top;
   logic              is_branch, cond_hit, push_req, pop_req;
   logic              stk_full, stk_empty;
   cond_sel_e         csel;

   assign pc_inc   = pc + 1'b1;
   assign push_req = step_en && (op_code == OP_CALL);
   assign pop_req  = step_en && (op_code == OP_RET);

   always_comb begin
      is_branch = 1'b1;
      csel      = COND_ALWAYS;
      unique case (op_code)
         OP_JMP:  csel = COND_ALWAYS;
         OP_JZ:   csel = COND_ZERO;
         OP_JPOS: csel = COND_POS;
         OP_JNEG: csel = COND_NEG;
         default: is_branch = 1'b0;
      endcase
   end

   flow_cond_eval #(.DATA_W(DATA_W)) u_cond (
      .sel (csel),
      .val (test_val),
      .hit (cond_hit)
   );

   flow_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_req),
      .pop       (pop_req),
      .push_data (pc_inc),
      .top       (stk_top),
      .count     (stk_depth),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   always_comb begin
      if (is_branch)
         pc_nxt = cond_hit ? target : pc_inc;
      else if (op_code == OP_CALL)
         pc_nxt = stk_full ? pc_inc : target;
      else if (op_code == OP_RET)
         pc_nxt = stk_empty ? pc_inc : stk_top;
      else
         pc_nxt = pc_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc      <= '0;
         ovf_err <= 1'b0;
         unf_err <= 1'b0;
      end else if (step_en) begin
         pc      <= pc_nxt;
         ovf_err <= ovf_err | (push_req & stk_full);
         unf_err <= unf_err | (pop_req & stk_empty);
      end
   end
endmodule

module flow_sequencer_chk
   import flow_seq_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 32,
   parameter int STACK_DEPTH = 8,
   localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_en,
   input logic [OPC_W-1:0]  op_code,
   input logic [ADDR_W-1:0] target,
   input logic [DATA_W-1:0] test_val,
   input logic [ADDR_W-1:0] pc,
   input logic [CNT_W-1:0]  stk_depth,
   input logic              ovf_err,
   input logic              unf_err
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(STACK_DEPTH);

   a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      stk_depth <= FULL_CNT);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(pc) && $stable(stk_depth) && $stable(ovf_err) && $stable(unf_err));

   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && (op_code < OP_JMP || op_code > OP_RET) |=> pc == ADDR_W'($past(pc) + 1'b1));

   a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_JMP |=> pc == $past(target));

   a_r5_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_JZ && test_val == '0 |=> pc == $past(target));

   a_r7_jneg_not: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_JNEG && !test_val[DATA_W-1] |=> pc == ADDR_W'($past(pc) + 1'b1));

   a_r8_call_push: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_CALL && stk_depth < FULL_CNT
      |=> pc == $past(target) && stk_depth == $past(stk_depth) + 1'b1);

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_CALL && stk_depth == FULL_CNT
      |=> ovf_err && stk_depth == FULL_CNT && pc == ADDR_W'($past(pc) + 1'b1));

   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && op_code == OP_RET && stk_depth == '0
      |=> unf_err && stk_depth == '0 && pc == ADDR_W'($past(pc) + 1'b1));

   a_r11_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err |=> unf_err);
endmodule

bind flow_sequencer flow_sequencer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_code(op_code),
   .target(target), .test_val(test_val), .pc(pc), .stk_depth(stk_depth),
   .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/flow_sequencer_bench.sv
`timescale 1ns/1ps
module flow_sequencer_bench;
   localparam int AW = 22;
   localparam int DW = 32;
   localparam int SD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          step_en = 1'b0;
   logic [4:0]    op_code = '0;
   logic [AW-1:0] target = '0;
   logic [DW-1:0] test_val = '0;
   logic [AW-1:0] pc;
   logic [3:0]    stk_depth;
   logic          ovf_err, unf_err;

   always #2.5 clk = ~clk;

   flow_sequencer u_flow_sequencer (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .op_code(op_code),
      .target(target), .test_val(test_val), .pc(pc), .stk_depth(stk_depth),
      .ovf_err(ovf_err), .unf_err(unf_err)
   );

   typedef struct {
      logic [AW-1:0] pc;
      int            depth;
      logic          ovf;
      logic          unf;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [AW-1:0] mstk[$];
   logic [AW-1:0] mpc = '0;
   logic          movf = 1'b0, munf = 1'b0;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   task automatic expect_now(input string tag);
      exp_t e;
      e.pc = mpc; e.depth = mstk.size(); e.ovf = movf; e.unf = munf; e.tag = tag;
      sb.push_back(e);
   endtask

   // driver: one instruction step, reference model updated from the requirements
   task automatic step(input logic [4:0] op, input logic [AW-1:0] tgt,
                       input logic [DW-1:0] val, input string tag);
      logic [AW-1:0] inc;
      @(negedge clk);
      op_code = op; target = tgt; test_val = val; step_en = 1'b1;
      inc = mpc + 1'b1;
      case (op)
         5'b10000: mpc = tgt;
         5'b10001: mpc = (val == '0) ? tgt : inc;
         5'b10010: mpc = ($signed(val) > 0) ? tgt : inc;
         5'b10011: mpc = val[DW-1] ? tgt : inc;
         5'b10100: if (mstk.size() == SD) begin movf = 1'b1; mpc = inc; end
                   else begin mstk.push_back(inc); mpc = tgt; end
         5'b10101: if (mstk.size() == 0) begin munf = 1'b1; mpc = inc; end
                   else mpc = mstk.pop_back();
         default:  mpc = inc;
      endcase
      @(posedge clk);
      expect_now(tag);
      @(negedge clk);
      step_en = 1'b0;
   endtask

   // inputs move without a step pulse: nothing may change (R2)
   task automatic idle(input logic [4:0] op, input logic [AW-1:0] tgt, input string tag);
      @(negedge clk);
      op_code = op; target = tgt; test_val = '0; step_en = 1'b0;
      @(posedge clk);
      @(posedge clk);
      expect_now(tag);
   endtask

   // monitor: compare against the scoreboard away from the active edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (pc !== e.pc || int'(stk_depth) != e.depth || ovf_err !== e.ovf || unf_err !== e.unf) begin
            errors++;
            $display("FAIL %s: actual pc=%h depth=%0d ovf=%b unf=%b expected pc=%h depth=%0d ovf=%b unf=%b",
                     e.tag, pc, stk_depth, ovf_err, unf_err, e.pc, e.depth, e.ovf, e.unf);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      expect_now("R1 state during reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_now("R1 state after release");

      step(5'b00000, 22'h12345, 32'd0, "R3 nop advances");
      step(5'b11010, 22'h00abc, 32'd0, "R3 unrelated opcode advances");
      step(5'b10110, 22'h00abc, 32'd0, "R3 opcode above return advances");
      idle(5'b10000, 22'h00155, "R2 jump without step is held");
      idle(5'b10100, 22'h00777, "R2 call without step is held");
      step(5'b10000, 22'h3fffff, 32'd0, "R4 jump to top address");
      step(5'b00001, 22'h0, 32'd0, "R3 wrap to zero");
      step(5'b10000, 22'h000040, 32'd0, "R4 jump");

      step(5'b10001, 22'h000100, 32'd0, "R5 zero taken");
      step(5'b10001, 22'h000200, 32'd5, "R5 nonzero not taken");
      step(5'b10001, 22'h000200, 32'h8000_0000, "R5 sign-only not taken");

      step(5'b10010, 22'h000300, 32'd0, "R6 zero not positive");
      step(5'b10010, 22'h000300, 32'd7, "R6 positive taken");
      step(5'b10010, 22'h000400, 32'h8000_0000, "R6 most negative not taken");
      step(5'b10010, 22'h000500, 32'h7fff_ffff, "R6 largest positive taken");

      step(5'b10011, 22'h000600, 32'hffff_ffff, "R7 minus one taken");
      step(5'b10011, 22'h000700, 32'd1, "R7 positive not taken");
      step(5'b10011, 22'h000700, 32'd0, "R7 zero not taken");

      step(5'b10101, 22'h0, 32'd0, "R11 return on empty");
      for (int i = 0; i < SD; i++)
         step(5'b10100, 22'h010000 + 22'(i * 16), 32'd0, "R8 call push");
      step(5'b10100, 22'h020000, 32'd0, "R10 call on full stack");
      step(5'b00000, 22'h0, 32'd0, "R10 overflow flag stays");
      for (int i = 0; i < SD; i++)
         step(5'b10101, 22'h0, 32'd0, "R9 return LIFO");
      step(5'b10101, 22'h0, 32'd0, "R11 second empty return");
      step(5'b00000, 22'h0, 32'd0, "R11 underflow flag stays");

      @(negedge clk);
      rst_n = 1'b0;
      mpc = '0; movf = 1'b0; munf = 1'b0; mstk.delete();
      @(negedge clk);
      expect_now("R1 reset clears flags");
      @(negedge clk);
      rst_n = 1'b1;
      step(5'b10100, 22'h000abc, 32'd0, "R8 call after reset");
      step(5'b10101, 22'h0, 32'd0, "R9 return after reset");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule